// File: doc/BRIEF.md
# Four-Counter Tick Timer Bank

This peripheral holds four counters behind a plain 32-bit register bus. The bus has an address, a write strobe, a read strobe, write data and read data, all in the core clock domain. Three of the counters count down and reload themselves. Two of these are 16 bits wide and one is 32 bits wide. Each can raise a sticky interrupt when it passes zero. The fourth counter is 40 bits wide and counts up freely with no interrupt. Software reads it as a low word and a high word.

No counter runs on its own clock. Each one advances on a single-cycle tick-enable pulse:

- The down-counters choose per timer between a fast tick of about 508 kHz and a slow tick.
- The free-running counter advances on its own tick of 983.04 kHz.

Software programs a down-counter in three writes: clear the enable, write the start value, then set the enable. It acknowledges an interrupt by writing any value to that timer's clear register.

Top module: `tmrbank`

## Requirements
- R1: After reset every start value, count, control field, interrupt and the free-running counter are zero, and so is its enable.
- R2: Each down-timer has four registers: start value at base+0x0, live count at base+0x4, control at base+0x8, interrupt clear at base+0xC. The bases are 0x00, 0x20 and 0x80 for timers 0, 1 and 2. A read of any unmapped address returns zero.
- R3: A write to a start-value register sets both the stored start value and the live count, cut to the timer width: 16, 16 and 32 bits. Both read back zero-extended.
- R4: While control bit 7 (enable) is set, the count drops by one per tick of the selected source. Control bit 3 set selects the fast tick and bit 3 clear selects the slow tick. Pulses on the unselected tick do not change the count.
- R5: A control read returns bits 7, 6 and 3 as written and zero elsewhere. With bit 7 clear, the count holds whatever the ticks do.
- R6: A tick at count zero with control bit 6 (periodic) set loads the stored start value into the count.
- R7: A tick at count zero with bit 6 clear sets the count to all ones of the timer width.
- R8: Every zero-crossing sets that timer's interrupt output, and it stays set until a write of any value to the timer's clear register.
- R9: If a clear write and a zero-crossing of the same timer fall in the same cycle, the interrupt stays set.
- R10: If a start-value write and a counting tick fall in the same cycle, the count takes the written value.
- R11: The free-running counter adds one per free tick while bit 8 of the register at 0x64 is set, and holds while that bit is clear. Writing 0x64 sets the bit. The counter never drives an interrupt.
- R12: A read of 0x60 returns count bits 31:0 and in the same cycle captures bits 39:32. A later read of 0x64 returns the captured byte in bits 7:0 and the enable in bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_fast | input | 1 | Fast count enable for the down-timers |
| tick_slow | input | 1 | Slow count enable for the down-timers |
| tick_free | input | 1 | Count enable for the free-running counter |
| irq | output | 3 | Sticky interrupt per down-timer, bit n for timer n |

## Verification
Two pairs of events can land on the same edge.

- **Clear write and zero-crossing.** A timer is left at count zero with its interrupt already pending. The bench then raises the clear write and a fast tick in the same cycle. The interrupt must still be high afterwards, and a later clear on its own must drop it.
- **Start-value write and counting tick.** The bench writes a start value while a selected tick is high. The count read back must equal the written value, with no decrement applied.

// File: rtl/tmrbank_pkg.sv
package tmrbank_pkg;

    // control field bit positions
    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_PER_BIT  = 6;
    localparam int CTRL_FAST_BIT = 3;
    localparam int FREE_EN_BIT   = 8;

    // register map
    localparam logic [7:0] TMR0_BASE = 8'h00;
    localparam logic [7:0] TMR1_BASE = 8'h20;
    localparam logic [7:0] TMR2_BASE = 8'h80;
    localparam logic [7:0] FREE_LO   = 8'h60;
    localparam logic [7:0] FREE_HI   = 8'h64;
    localparam logic [7:0] OFS_LOAD  = 8'h00;
    localparam logic [7:0] OFS_VAL   = 8'h04;
    localparam logic [7:0] OFS_CTRL  = 8'h08;
    localparam logic [7:0] OFS_CLR   = 8'h0C;

    typedef struct packed {
        logic en;
        logic per;
        logic fast;
    } ctrl_t;

endpackage

// File: rtl/tmrbank_down.sv
module tmrbank_down
    import tmrbank_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_we,
    input  logic [W-1:0] load_val,
    input  logic         ctrl_we,
    input  ctrl_t        ctrl_val,
    input  logic         clr_we,
    input  logic         tick_fast,
    input  logic         tick_slow,
    output logic [W-1:0] load_o,
    output logic [W-1:0] cnt_o,
    output ctrl_t        ctrl_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [W-1:0] load;
        logic [W-1:0] cnt;
        ctrl_t        ctrl;
        logic         irq;
    } st_t;

    st_t  st_d, st_q;
    logic tick_sel;
    logic uflow;

    always_comb begin
        st_d     = st_q;
        uflow    = 1'b0;
        tick_sel = st_q.ctrl.fast ? tick_fast : tick_slow;
        if (load_we) begin
            st_d.load = load_val;
            st_d.cnt  = load_val;
        end else if (st_q.ctrl.en && tick_sel) begin
            if (st_q.cnt == '0) begin
                uflow    = 1'b1;
                st_d.cnt = st_q.ctrl.per ? st_q.load : {W{1'b1}};
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (ctrl_we) st_d.ctrl = ctrl_val;
        st_d.irq = (st_q.irq & ~clr_we) | uflow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_o = st_q.load;
    assign cnt_o  = st_q.cnt;
    assign ctrl_o = st_q.ctrl;
    assign irq_o  = st_q.irq;

    p_uflow_sets_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> irq_o);
    p_clear_drops_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !uflow) |=> !irq_o);
    p_clear_vs_uflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && uflow) |=> irq_o);
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && st_q.ctrl.per) |=> (cnt_o == $past(st_q.load)));
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && !st_q.ctrl.per) |=> (cnt_o == {W{1'b1}}));
    p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.en && !load_we) |=> $stable(cnt_o));
    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (cnt_o == $past(load_val)));

endmodule

// File: rtl/tmrbank_free.sv
module tmrbank_free #(
    parameter int W = 40
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_we,
    input  logic           en_val,
    input  logic           rd_lo,
    input  logic           tick,
    output logic [W-1:0]   cnt_o,
    output logic [W-33:0]  shadow_o,
    output logic           en_o
);

    localparam int HI_W = W - 32;

    typedef struct packed {
        logic [W-1:0]    cnt;
        logic [HI_W-1:0] shadow;
        logic            en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.en && tick) st_d.cnt = st_q.cnt + 1'b1;
        if (rd_lo)           st_d.shadow = st_q.cnt[W-1:32];
        if (en_we)           st_d.en = en_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign shadow_o = st_q.shadow;
    assign en_o     = st_q.en;

    p_free_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |=> $stable(cnt_o));
    p_free_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && tick) |=> (cnt_o == $past(cnt_o) + 1'b1));
    p_shadow_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (shadow_o == $past(cnt_o[W-1:32])));

endmodule

// File: rtl/tmrbank.sv
module tmrbank
    import tmrbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int T0_W   = 16,
    parameter int T1_W   = 16,
    parameter int T2_W   = 32,
    parameter int FREE_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic              tick_free,
    output logic [2:0]        irq
);

    localparam int N_TMR = 3;
    localparam int TW [N_TMR] = '{T0_W, T1_W, T2_W};
    localparam logic [7:0] BASES [N_TMR] = '{TMR0_BASE, TMR1_BASE, TMR2_BASE};
    localparam int HI_W = FREE_W - 32;

    logic [DATA_W-1:0] rd_part [N_TMR];
    ctrl_t             ctrl_val;

    assign ctrl_val.en   = bus_wdata[CTRL_EN_BIT];
    assign ctrl_val.per  = bus_wdata[CTRL_PER_BIT];
    assign ctrl_val.fast = bus_wdata[CTRL_FAST_BIT];

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(BASES[i] + OFS_LOAD);
        localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(BASES[i] + OFS_VAL);
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASES[i] + OFS_CTRL);
        localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASES[i] + OFS_CLR);

        logic [TW[i]-1:0] load_w, cnt_w;
        ctrl_t            ctrl_w;
        logic             irq_w;
        logic [DATA_W-1:0] ctrl_word;

        tmrbank_down #(.W(TW[i])) u_down (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_we   (bus_wr && bus_addr == A_LOAD),
            .load_val  (bus_wdata[TW[i]-1:0]),
            .ctrl_we   (bus_wr && bus_addr == A_CTRL),
            .ctrl_val  (ctrl_val),
            .clr_we    (bus_wr && bus_addr == A_CLR),
            .tick_fast (tick_fast),
            .tick_slow (tick_slow),
            .load_o    (load_w),
            .cnt_o     (cnt_w),
            .ctrl_o    (ctrl_w),
            .irq_o     (irq_w)
        );

        always_comb begin
            ctrl_word                = '0;
            ctrl_word[CTRL_EN_BIT]   = ctrl_w.en;
            ctrl_word[CTRL_PER_BIT]  = ctrl_w.per;
            ctrl_word[CTRL_FAST_BIT] = ctrl_w.fast;
            if (bus_addr == A_LOAD)      rd_part[i] = DATA_W'(load_w);
            else if (bus_addr == A_VAL)  rd_part[i] = DATA_W'(cnt_w);
            else if (bus_addr == A_CTRL) rd_part[i] = ctrl_word;
            else                         rd_part[i] = '0;
        end

        assign irq[i] = irq_w;
    end

    logic [FREE_W-1:0] free_cnt;
    logic [HI_W-1:0]   free_shadow;
    logic              free_en;
    logic [DATA_W-1:0] free_part;

    tmrbank_free #(.W(FREE_W)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we    (bus_wr && bus_addr == ADDR_W'(FREE_HI)),
        .en_val   (bus_wdata[FREE_EN_BIT]),
        .rd_lo    (bus_rd && bus_addr == ADDR_W'(FREE_LO)),
        .tick     (tick_free),
        .cnt_o    (free_cnt),
        .shadow_o (free_shadow),
        .en_o     (free_en)
    );

    always_comb begin
        free_part = '0;
        if (bus_addr == ADDR_W'(FREE_LO)) begin
            free_part = free_cnt[31:0];
        end else if (bus_addr == ADDR_W'(FREE_HI)) begin
            free_part[HI_W-1:0]  = free_shadow;
            free_part[FREE_EN_BIT] = free_en;
        end
    end

    assign bus_rdata = rd_part[0] | rd_part[1] | rd_part[2] | free_part;

endmodule

// File: tb/tmrbank_tb.sv
module tmrbank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        tick_free = 1'b0;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmrbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .tick_free(tick_free),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // which: 0 fast, 1 slow, 2 free
    task automatic pulse(input int which, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (which == 0) tick_fast = 1'b1;
            else if (which == 1) tick_slow = 1'b1;
            else tick_free = 1'b1;
            @(negedge clk);
            tick_fast = 1'b0; tick_slow = 1'b0; tick_free = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h04, d); chk("R1 t0 count", d, 0);
        rd(8'h88, d); chk("R1 t2 ctrl", d, 0);
        rd(8'h64, d); chk("R1 free hi", d, 0);
        rd(8'h60, d); chk("R1 free lo", d, 0);
        chk("R1 irq", {29'b0, irq}, 0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        wr(8'h00, 32'h0001_2345);
        rd(8'h00, d); chk("R3 t0 start cut 16", d, 32'h2345);
        rd(8'h04, d); chk("R3 t0 count cut 16", d, 32'h2345);
        wr(8'h80, 32'hFFFF_FFF0);
        rd(8'h84, d); chk("R3 t2 count 32", d, 32'hFFFF_FFF0);
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, d); chk("R5 ctrl readback", d, 32'h0000_00C8);
        wr(8'h28, 32'h0);
        rd(8'h40, d); chk("R2 unmapped read", d, 0);
    endtask

    task automatic t_fast_count;
        logic [31:0] d;
        wr(8'h08, 32'h48);
        wr(8'h00, 32'd5);
        wr(8'h08, 32'hC8);
        pulse(0, 3);
        rd(8'h04, d); chk("R4 fast decrement", d, 2);
        pulse(1, 2);
        rd(8'h04, d); chk("R4 slow ignored when fast selected", d, 2);
        wr(8'h08, 32'h0);
        pulse(0, 2);
        rd(8'h04, d); chk("R5 holds when disabled", d, 2);
    endtask

    task automatic t_periodic;
        logic [31:0] d;
        wr(8'h08, 32'h48);
        wr(8'h00, 32'd2);
        wr(8'h08, 32'hC8);
        pulse(0, 2);
        chk("R8 no irq before crossing", {31'b0, irq[0]}, 0);
        pulse(0, 1);
        rd(8'h04, d); chk("R6 periodic reload", d, 2);
        chk("R8 irq set on crossing", {31'b0, irq[0]}, 1);
        pulse(0, 1);
        chk("R8 irq sticky", {31'b0, irq[0]}, 1);
        wr(8'h0C, 32'h0);
        chk("R8 clear drops irq", {31'b0, irq[0]}, 0);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        wr(8'h28, 32'h08);
        wr(8'h20, 32'd1);
        wr(8'h28, 32'h88);
        pulse(0, 2);
        rd(8'h24, d); chk("R7 wrap to all ones 16", d, 32'hFFFF);
        chk("R8 irq t1", {31'b0, irq[1]}, 1);
        wr(8'h2C, 32'h5A);
        chk("R8 t1 clear", {31'b0, irq[1]}, 0);
    endtask

    task automatic t_slow;
        logic [31:0] d;
        wr(8'h88, 32'h0);
        wr(8'h80, 32'd10);
        wr(8'h88, 32'h80);
        pulse(1, 4);
        rd(8'h84, d); chk("R4 slow decrement", d, 6);
        pulse(0, 3);
        rd(8'h84, d); chk("R4 fast ignored when slow selected", d, 6);
        wr(8'h88, 32'h0);
    endtask

    task automatic t_clear_race;
        logic [31:0] d;
        wr(8'h08, 32'h48);
        wr(8'h00, 32'd0);
        wr(8'h08, 32'hC8);
        pulse(0, 1);
        chk("R9 setup irq pending", {31'b0, irq[0]}, 1);
        @(negedge clk);
        bus_addr = 8'h0C; bus_wr = 1'b1; tick_fast = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_fast = 1'b0;
        chk("R9 clear with crossing keeps irq", {31'b0, irq[0]}, 1);
        wr(8'h0C, 32'h1);
        chk("R9 later clear drops irq", {31'b0, irq[0]}, 0);
        wr(8'h00, 32'd9);
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'd7; bus_wr = 1'b1; tick_fast = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_fast = 1'b0;
        rd(8'h04, d); chk("R10 start write beats tick", d, 7);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_free;
        logic [31:0] d;
        pulse(2, 2);
        rd(8'h60, d); chk("R11 holds before enable", d, 0);
        wr(8'h64, 32'h100);
        pulse(2, 5);
        rd(8'h60, d); chk("R11 counts free ticks", d, 5);
        rd(8'h64, d); chk("R12 hi word shadow and enable", d, 32'h100);
        wr(8'h64, 32'h0);
        pulse(2, 3);
        rd(8'h60, d); chk("R11 holds when disabled", d, 5);
        chk("R11 no interrupt", {29'b0, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_fast_count();
        t_periodic();
        t_wrap();
        t_slow();
        t_clear_race();
        t_free();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule